// File: doc/BRIEF.md
# Floating-Point Coprocessor System Register Access Unit

This block holds the system registers of a floating-point coprocessor and serves the move-to and move-from commands that a core issues against them. Each command arrives as a register selector, a general-register index, a condition code with a condition-pass flag, the current privilege level, and a read or write strobe. Reads return the selected register one cycle later with a one-cycle valid pulse. A status read aimed at the program-counter index does not return data. It loads the four top status bits into the core's negative, zero, carry and overflow flags instead.

Access rights depend on the selector and the privilege level. The status/control register is open in every mode. The identification register and the two feature registers are read-only in every mode. The exception-control register and the two instruction registers are reachable only while the core is privileged. A command that is not allowed, not executed or aimed at an unknown selector is dropped silently: it produces no pulse and changes no state. Reset values, the feature values and the identification fields are fixed by parameters.

Top module: `fpsr_access_unit`

## Requirements
- R1: After reset, status and exception control read 0, the instruction register reads 0xEE000A00, instruction register 2 reads 0, `nzcv` is 0 and neither `rd_valid` nor `flags_upd` is set.
- R2: Selector 1 (status/control, all 32 bits) can be written and read back whether `priv` is 0 or 1.
- R3: A read of selector 0 succeeds in any mode and returns {implementer[7:0], software flag, sub-architecture[6:0], part[7:0], variant[3:0], revision[3:0]} from the most significant bit down. The defaults are 0x41, 0, 0x01, 0x20, 0xB and 0x4, giving 0x41012 0B4.
- R4: A read of selector 7 returns 0x11111111 and a read of selector 6 returns 0, in any mode.
- R5: Selectors 8 (exception control), 9 (instruction) and 10 (instruction 2) can be read and written only when `priv`=1. With `priv`=0 a read gives no `rd_valid` and leaves `rd_data` unchanged, and a write leaves the register unchanged.
- R6: Writes to selectors 0, 6 and 7, and writes to any selector outside {0,1,6,7,8,9,10}, change no register. Reads of such unknown selectors give no `rd_valid`.
- R7: A permitted read of selector 1 with `gpr_idx`=15 loads `nzcv` with status bits 31..28, in that order, and pulses `flags_upd` one cycle later. It raises no `rd_valid` and leaves `rd_data` unchanged. No other command changes `nzcv`.
- R8: A command executes only when `cond`=0xE or `cond_pass`=1. Otherwise it reads nothing, writes nothing and changes no flags.
- R9: `rd_data` and `rd_valid` are registered. They are valid in the cycle after the read strobe. `rd_valid` lasts one cycle per read, and `rd_data` holds its value between successful reads.
- R10: When a read and a write to the same register are strobed together, the read returns the value held before the write, and the write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Move-from (read) strobe |
| wr_en | input | 1 | Move-to (write) strobe |
| sel | input | 4 | System register selector |
| gpr_idx | input | 4 | General-register index of the command (15 = program counter) |
| cond | input | 4 | Condition code of the command |
| cond_pass | input | 1 | Condition evaluated true by the core |
| priv | input | 1 | Core is in a privileged mode |
| wr_data | input | 32 | Data for a write |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` updated |
| nzcv | output | 4 | Flags loaded by a status transfer (N,Z,C,V from bit 3 down) |
| flags_upd | output | 1 | One-cycle pulse: `nzcv` loaded |

## Verification
The selector is swept with `priv` both low and high, so open, privileged-only, read-only and unknown selectors are each checked against the reference model. A wrong permission gives a pulse or a register change that the model does not expect. Condition codes other than 0xE are combined with both `cond_pass` values, which separates an executed command from a dropped one. Status reads go to index 15 and to other indices with varied upper bits, which checks both the flag-transfer path and the ordinary read path. Reads and writes strobed in the same cycle show that the read returns the old value. The random phase mixes all of these patterns, and every command's outputs are compared cycle by cycle against the bench's model.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int XLEN    = 32;
    localparam int SEL_W   = 4;
    localparam int IDX_W   = 4;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;
    localparam int BANK_N  = 4;
    localparam int SLOT_W  = $clog2(BANK_N);

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;
    localparam logic [IDX_W-1:0]  PC_IDX      = 4'hF;

    // selector codes seen by the core
    localparam logic [SEL_W-1:0] SEL_IDENT = 4'd0;
    localparam logic [SEL_W-1:0] SEL_STAT  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_FEATB = 4'd6;
    localparam logic [SEL_W-1:0] SEL_FEATA = 4'd7;
    localparam logic [SEL_W-1:0] SEL_XCTL  = 4'd8;
    localparam logic [SEL_W-1:0] SEL_INSA  = 4'd9;
    localparam logic [SEL_W-1:0] SEL_INSB  = 4'd10;

    // storage slots of the writable bank
    localparam logic [SLOT_W-1:0] SLOT_STAT = 2'd0;
    localparam logic [SLOT_W-1:0] SLOT_XCTL = 2'd1;
    localparam logic [SLOT_W-1:0] SLOT_INSA = 2'd2;
    localparam logic [SLOT_W-1:0] SLOT_INSB = 2'd3;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_IDENT,
        RK_STAT,
        RK_FEATA,
        RK_FEATB,
        RK_XCTL,
        RK_INSA,
        RK_INSB
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      rd_ok;
        logic      wr_ok;
        logic      flag_xfer;
    } access_t;

    function automatic reg_kind_e decode_kind(input logic [SEL_W-1:0] s);
        case (s)
            SEL_IDENT: return RK_IDENT;
            SEL_STAT:  return RK_STAT;
            SEL_FEATA: return RK_FEATA;
            SEL_FEATB: return RK_FEATB;
            SEL_XCTL:  return RK_XCTL;
            SEL_INSA:  return RK_INSA;
            SEL_INSB:  return RK_INSB;
            default:   return RK_NONE;
        endcase
    endfunction

    function automatic logic kind_needs_priv(input reg_kind_e k);
        return (k == RK_XCTL) || (k == RK_INSA) || (k == RK_INSB);
    endfunction

    function automatic logic kind_writable(input reg_kind_e k);
        return (k == RK_STAT) || kind_needs_priv(k);
    endfunction

    function automatic logic [SLOT_W-1:0] kind_slot(input reg_kind_e k);
        case (k)
            RK_XCTL: return SLOT_XCTL;
            RK_INSA: return SLOT_INSA;
            RK_INSB: return SLOT_INSB;
            default: return SLOT_STAT;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] build_ident(
        input logic [7:0] impl,
        input logic       sw,
        input logic [6:0] subarch,
        input logic [7:0] part,
        input logic [3:0] variant,
        input logic [3:0] rev
    );
        return {impl, sw, subarch, part, variant, rev};
    endfunction

endpackage

// File: rtl/fpsr_access_gate.sv
module fpsr_access_gate
    import fpsr_pkg::*;
(
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  gpr_idx,
    input  logic [COND_W-1:0] cond,
    input  logic              cond_pass,
    input  logic              priv,
    output access_t           acc
);
    reg_kind_e kind;
    logic      executes;
    logic      permitted;
    logic      to_pc;

    always_comb begin
        kind      = decode_kind(sel);
        executes  = (cond == COND_ALWAYS) || cond_pass;
        permitted = (kind != RK_NONE) && (!kind_needs_priv(kind) || priv);
        to_pc     = (kind == RK_STAT) && (gpr_idx == PC_IDX);

        acc.kind      = kind;
        acc.rd_ok     = executes && rd_en && permitted && !to_pc;
        acc.flag_xfer = executes && rd_en && permitted && to_pc;
        acc.wr_ok     = executes && wr_en && permitted && kind_writable(kind);
    end
endmodule

// File: rtl/fpsr_reg_bank.sv
module fpsr_reg_bank
    import fpsr_pkg::*;
#(
    parameter logic [XLEN-1:0] INSA_RST = 32'hEE00_0A00
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_ok,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [XLEN-1:0]             wr_data,
    output logic [BANK_N-1:0][XLEN-1:0] regs
);
    for (genvar g = 0; g < BANK_N; g++) begin : g_slot
        localparam logic [XLEN-1:0] RST_VAL =
            (g == int'(SLOT_INSA)) ? INSA_RST : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (wr_ok && (wr_slot == SLOT_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fpsr_read_mux.sv
module fpsr_read_mux
    import fpsr_pkg::*;
#(
    parameter logic [XLEN-1:0] IDENT_VAL = '0,
    parameter logic [XLEN-1:0] FEATA_VAL = 32'h1111_1111,
    parameter logic [XLEN-1:0] FEATB_VAL = '0
) (
    input  reg_kind_e                   kind,
    input  logic [BANK_N-1:0][XLEN-1:0] regs,
    output logic [XLEN-1:0]             value
);
    always_comb begin
        case (kind)
            RK_IDENT: value = IDENT_VAL;
            RK_FEATA: value = FEATA_VAL;
            RK_FEATB: value = FEATB_VAL;
            RK_STAT:  value = regs[SLOT_STAT];
            RK_XCTL:  value = regs[SLOT_XCTL];
            RK_INSA:  value = regs[SLOT_INSA];
            RK_INSB:  value = regs[SLOT_INSB];
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/fpsr_access_unit.sv
module fpsr_access_unit
    import fpsr_pkg::*;
#(
    parameter logic [7:0]      ID_IMPL    = 8'h41,
    parameter logic            ID_SW      = 1'b0,
    parameter logic [6:0]      ID_SUBARCH = 7'h01,
    parameter logic [7:0]      ID_PART    = 8'h20,
    parameter logic [3:0]      ID_VARIANT = 4'hB,
    parameter logic [3:0]      ID_REV     = 4'h4,
    parameter logic [31:0]     INSA_RST   = 32'hEE00_0A00,
    parameter logic [31:0]     FEATA_VAL  = 32'h1111_1111,
    parameter logic [31:0]     FEATB_VAL  = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [3:0]  sel,
    input  logic [3:0]  gpr_idx,
    input  logic [3:0]  cond,
    input  logic        cond_pass,
    input  logic        priv,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic [3:0]  nzcv,
    output logic        flags_upd
);
    localparam logic [XLEN-1:0] IDENT_VAL =
        build_ident(ID_IMPL, ID_SW, ID_SUBARCH, ID_PART, ID_VARIANT, ID_REV);

    access_t                     acc;
    logic [BANK_N-1:0][XLEN-1:0] regs;
    logic [XLEN-1:0]             rd_value;
    logic [XLEN-1:0]             stat_now;

    fpsr_access_gate u_gate (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .sel       (sel),
        .gpr_idx   (gpr_idx),
        .cond      (cond),
        .cond_pass (cond_pass),
        .priv      (priv),
        .acc       (acc)
    );

    fpsr_reg_bank #(
        .INSA_RST (INSA_RST)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (acc.wr_ok),
        .wr_slot (kind_slot(acc.kind)),
        .wr_data (wr_data),
        .regs    (regs)
    );

    fpsr_read_mux #(
        .IDENT_VAL (IDENT_VAL),
        .FEATA_VAL (FEATA_VAL),
        .FEATB_VAL (FEATB_VAL)
    ) u_mux (
        .kind  (acc.kind),
        .regs  (regs),
        .value (rd_value)
    );

    assign stat_now = regs[SLOT_STAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            nzcv      <= '0;
            flags_upd <= 1'b0;
        end else begin
            rd_valid  <= acc.rd_ok;
            flags_upd <= acc.flag_xfer;
            if (acc.rd_ok) begin
                rd_data <= rd_value;
            end
            if (acc.flag_xfer) begin
                nzcv <= stat_now[XLEN-1 -: FLAG_W];
            end
        end
    end
endmodule

// File: rtl/fpsr_access_chk.sv
module fpsr_access_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [3:0]  sel,
    input logic [3:0]  gpr_idx,
    input logic [3:0]  cond,
    input logic        cond_pass,
    input logic        priv,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic [3:0]  nzcv,
    input logic        flags_upd
);
    // R9: a valid pulse always follows a read strobe
    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    // R8: a command that does not execute leaves no trace
    a_r8_cond_fail_silent: assert property (@(posedge clk) disable iff (rst)
        (cond != 4'hE && !cond_pass) |=> (!rd_valid && !flags_upd));

    // R5: privileged selectors answer only in privileged mode
    a_r5_priv_read: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(sel) >= 4'd8) |-> $past(priv));

    // R7: flag transfer comes from a status read to index 15 and never with data
    a_r7_flag_source: assert property (@(posedge clk) disable iff (rst)
        flags_upd |-> ($past(sel) == 4'd1 && $past(gpr_idx) == 4'hF && !rd_valid));

    // R7: flags move only on a transfer
    a_r7_nzcv_hold: assert property (@(posedge clk) disable iff (rst)
        !flags_upd |-> $stable(nzcv));

    // R9: read data holds between successful reads
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));

    // R4: feature register 0 value
    a_r4_feat0_value: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(sel) == 4'd7) |-> rd_data == 32'h1111_1111);

    // R6: unknown selectors never answer
    a_r6_unknown_silent: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(sel) <= 4'd1 || ($past(sel) >= 4'd6 && $past(sel) <= 4'd10)));
endmodule

bind fpsr_access_unit fpsr_access_chk u_chk (.*);

// File: tb/tb_fpsr_access_unit.sv
module tb_fpsr_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EXP_IDENT = {8'h41, 1'b0, 7'h01, 8'h20, 4'hB, 4'h4};

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en, wr_en, cond_pass, priv;
    logic [3:0]  sel, gpr_idx, cond;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        rd_valid, flags_upd;
    logic [3:0]  nzcv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [31:0] m_stat, m_xctl, m_insa, m_insb, m_data;
    logic [3:0]  m_nzcv;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsr_access_unit dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
        .gpr_idx(gpr_idx), .cond(cond), .cond_pass(cond_pass), .priv(priv),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .nzcv(nzcv), .flags_upd(flags_upd)
    );

    function automatic bit m_known(input logic [3:0] s);
        return s == 0 || s == 1 || s == 6 || s == 7 || s == 8 || s == 9 || s == 10;
    endfunction

    function automatic bit m_allowed(input logic [3:0] s, input bit pv);
        if (!m_known(s)) return 0;
        if (s >= 8) return pv;
        return 1;
    endfunction

    function automatic logic [31:0] m_value(input logic [3:0] s);
        case (s)
            4'd0:  return EXP_IDENT;
            4'd1:  return m_stat;
            4'd6:  return 32'h0;
            4'd7:  return 32'h1111_1111;
            4'd8:  return m_xctl;
            4'd9:  return m_insa;
            4'd10: return m_insb;
            default: return 32'h0;
        endcase
    endfunction

    task automatic report(input string tag, input bit e_v, input bit e_f);
        checks++;
        if (rd_valid !== e_v || rd_data !== m_data || flags_upd !== e_f || nzcv !== m_nzcv) begin
            fails++;
            $display("FAIL %s: got valid=%0b data=%h flag=%0b nzcv=%h exp valid=%0b data=%h flag=%0b nzcv=%h",
                     tag, rd_valid, rd_data, flags_upd, nzcv, e_v, m_data, e_f, m_nzcv);
        end
    endtask

    task automatic access(input string tag, input bit rd, input bit wr,
                          input logic [3:0] s, input logic [3:0] idx,
                          input logic [3:0] c, input bit cp, input bit pv,
                          input logic [31:0] wd);
        bit exe, ok, fx, rok, wok;
        logic [31:0] val;
        @(negedge clk);
        rd_en = rd; wr_en = wr; sel = s; gpr_idx = idx; cond = c;
        cond_pass = cp; priv = pv; wr_data = wd;
        exe = (c == 4'hE) || cp;
        ok  = exe && m_allowed(s, pv);
        fx  = ok && rd && s == 1 && idx == 4'hF;
        rok = ok && rd && !fx;
        wok = ok && wr && (s == 1 || s >= 8);
        val = m_value(s);
        @(posedge clk);
        #1;
        rd_en = 0; wr_en = 0;
        if (rok) m_data = val;
        if (fx)  m_nzcv = m_stat[31:28];
        if (wok) begin
            case (s)
                4'd1: m_stat = wd;
                4'd8: m_xctl = wd;
                4'd9: m_insa = wd;
                default: m_insb = wd;
            endcase
        end
        report(tag, rok, fx);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        #1;
        report(tag, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; rd_en = 0; wr_en = 0; sel = 0; gpr_idx = 0; cond = 4'hE;
        cond_pass = 0; priv = 0; wr_data = 0;
        m_stat = 0; m_xctl = 0; m_insa = 32'hEE00_0A00; m_insb = 0;
        m_data = 0; m_nzcv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        idle("R1 outputs after reset");

        // R1: reset contents
        access("R1 status reset", 1, 0, 4'd1, 4'd2, 4'hE, 0, 1, 0);
        access("R1 xctl reset",   1, 0, 4'd8, 4'd2, 4'hE, 0, 1, 0);
        access("R1 insa reset",   1, 0, 4'd9, 4'd2, 4'hE, 0, 1, 0);
        access("R1 insb reset",   1, 0, 4'd10, 4'd2, 4'hE, 0, 1, 0);

        // R2: status open in both modes
        access("R2 write unpriv", 0, 1, 4'd1, 4'd3, 4'hE, 0, 0, 32'hA5C3_0F1E);
        access("R2 read priv",    1, 0, 4'd1, 4'd3, 4'hE, 0, 1, 0);
        access("R2 write priv",   0, 1, 4'd1, 4'd3, 4'hE, 0, 1, 32'h5000_1234);
        access("R2 read unpriv",  1, 0, 4'd1, 4'd3, 4'hE, 0, 0, 0);

        // R3 / R4: fixed registers in both modes
        access("R3 ident unpriv", 1, 0, 4'd0, 4'd1, 4'hE, 0, 0, 0);
        access("R4 feat0 unpriv", 1, 0, 4'd7, 4'd1, 4'hE, 0, 0, 0);
        access("R4 feat1 priv",   1, 0, 4'd6, 4'd1, 4'hE, 0, 1, 0);
        access("R3 ident priv",   1, 0, 4'd0, 4'd1, 4'hE, 0, 1, 0);

        // R5: privileged-only registers
        access("R5 write xctl unpriv", 0, 1, 4'd8, 4'd0, 4'hE, 0, 0, 32'hDEAD_BEEF);
        access("R5 read xctl unpriv",  1, 0, 4'd8, 4'd0, 4'hE, 0, 0, 0);
        access("R5 read xctl priv",    1, 0, 4'd8, 4'd0, 4'hE, 0, 1, 0);
        access("R5 write insa priv",   0, 1, 4'd9, 4'd0, 4'hE, 0, 1, 32'h1357_9BDF);
        access("R5 read insa priv",    1, 0, 4'd9, 4'd0, 4'hE, 0, 1, 0);
        access("R5 write insb priv",   0, 1, 4'd10, 4'd0, 4'hE, 0, 1, 32'h0246_8ACE);
        access("R5 read insb unpriv",  1, 0, 4'd10, 4'd0, 4'hE, 0, 0, 0);
        access("R5 read insb priv",    1, 0, 4'd10, 4'd0, 4'hE, 0, 1, 0);

        // R6: read-only and unknown selectors
        access("R6 write ident", 0, 1, 4'd0, 4'd0, 4'hE, 0, 1, 32'hFFFF_FFFF);
        access("R6 read ident",  1, 0, 4'd0, 4'd0, 4'hE, 0, 1, 0);
        access("R6 write feat0", 0, 1, 4'd7, 4'd0, 4'hE, 0, 1, 32'h0);
        access("R6 read feat0",  1, 0, 4'd7, 4'd0, 4'hE, 0, 1, 0);
        access("R6 write sel 3", 0, 1, 4'd3, 4'd0, 4'hE, 0, 1, 32'h7777_7777);
        access("R6 read sel 15", 1, 0, 4'd15, 4'd0, 4'hE, 0, 1, 0);
        access("R6 status intact", 1, 0, 4'd1, 4'd0, 4'hE, 0, 1, 0);

        // R7: flag transfer
        access("R7 set status", 0, 1, 4'd1, 4'd0, 4'hE, 0, 0, 32'hA000_0000);
        access("R7 transfer",   1, 0, 4'd1, 4'hF, 4'hE, 0, 0, 0);
        idle("R7 pulse ends");
        access("R7 other idx read", 1, 0, 4'd1, 4'hE, 4'hE, 0, 0, 0);
        access("R7 set status 2", 0, 1, 4'd1, 4'd0, 4'hE, 0, 0, 32'h5FFF_FFFF);
        access("R7 transfer 2",   1, 0, 4'd1, 4'hF, 4'hE, 0, 1, 0);
        access("R7 idx15 other sel", 1, 0, 4'd7, 4'hF, 4'hE, 0, 1, 0);

        // R8: condition gating
        access("R8 fail write", 0, 1, 4'd1, 4'd0, 4'h0, 0, 1, 32'h1111_0000);
        access("R8 fail read",  1, 0, 4'd0, 4'd0, 4'h3, 0, 1, 0);
        access("R8 fail xfer",  1, 0, 4'd1, 4'hF, 4'hF, 0, 1, 0);
        access("R8 pass write", 0, 1, 4'd1, 4'd0, 4'h0, 1, 1, 32'h9000_0001);
        access("R8 pass read",  1, 0, 4'd1, 4'd0, 4'h0, 1, 0, 0);

        // R9: single-cycle pulse and hold
        idle("R9 idle after read");
        idle("R9 second idle");

        // R10: read and write in the same cycle
        access("R10 rw status", 1, 1, 4'd1, 4'd0, 4'hE, 0, 0, 32'h0F0F_0F0F);
        access("R10 readback",  1, 0, 4'd1, 4'd0, 4'hE, 0, 0, 0);
        access("R10 rw insa",   1, 1, 4'd9, 4'd0, 4'hE, 0, 1, 32'hCAFE_F00D);
        access("R10 insa back", 1, 0, 4'd9, 4'd0, 4'hE, 0, 1, 0);

        // random mix, all requirements against the model
        for (int i = 0; i < 600; i++) begin
            logic [3:0] rs, ri, rc;
            bit rr, rw, rcp, rpv;
            rs  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0) rs = 4'($urandom_range(0, 10));
            ri  = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 15));
            rc  = ($urandom_range(0, 1) == 0) ? 4'hE : 4'($urandom_range(0, 15));
            rr  = 1'($urandom_range(0, 1));
            rw  = 1'($urandom_range(0, 1));
            rcp = 1'($urandom_range(0, 1));
            rpv = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 5) == 0) idle("R9 random idle");
            else access("R2-mix random", rr, rw, rs, ri, rc, rcp, rpv, $urandom);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule